// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This block sits between a bus master and a 512-byte window of peripheral registers whose native widths differ from location to location. The master may issue byte, halfword or word reads and writes to any register. The adapter turns each one into the sequence of native-width accesses the register port behind it expects, and returns a single response. No size mismatch is ever faulted. A wider access is split into pieces, with the lowest address carrying the most significant data. A narrower read picks its lane out of the enclosing register. A narrower write reads that register, merges in the new lane and writes the result back.

The native width of each 4-byte group comes from a small table built at elaboration time. Locations marked as unimplemented, and offsets outside the window, complete at once with no back-end cycle. The front end uses a ready/valid request and a one-cycle response strobe. The back end holds each request until it is acknowledged, so register logic of any latency can sit behind it.

Top module: `regwin_adapter`

## Requirements
- R1: After synchronous reset, req_ready is 1 and rsp_valid and be_valid are 0.
- R2: Only the low 10 bits of req_addr are decoded. An offset of 0x200 or above reads as 0 and a write there is dropped. Neither starts a back-end cycle, and rsp_valid rises in the cycle after acceptance.
- R3: Native width is chosen by offset bits [8:6]. The codes 0 and 6 to 7 select byte, 1 and 4 select halfword, 2 and 5 select word, and 3 is unimplemented (offsets 0x0C0 to 0x0FF). An unimplemented location reads 0, drops writes and starts no back-end cycle. Every back-end cycle has be_size equal to the native width of be_addr.
- R4: When the access size equals the native width, exactly one back-end cycle is made at the same offset. Data is right-aligned on both sides: byte in bits [7:0], halfword in [15:0].
- R5: A word access to a halfword region makes two halfword cycles: bits [31:16] at the offset first, then bits [15:0] at offset+2.
- R6: An access to a byte region that is wider than a byte makes one byte cycle per byte, in ascending address order. The lowest address carries the most significant byte: 2 cycles for a halfword access, 4 for a word access.
- R7: A read narrower than the native width makes one read cycle at the address aligned to the native width. It returns the addressed lane big-endian, so offset 0 within the register is its most significant byte or halfword.
- R8: A write narrower than the native width makes a read cycle and then a write cycle at the aligned address. The write replaces only the addressed lane and keeps the other bytes as they were read.
- R9: req_ready is 0 from the cycle after acceptance until the transaction ends. rsp_valid is high for exactly one cycle. A back-end request keeps its address, size, direction and data stable until be_ack.
- R10: Address bits below the access size are ignored, and a halfword access to 0x045 acts on 0x044. Size codes are 0 = byte, 1 = halfword, 2 = word, and code 3 is treated as word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Front-end request valid |
| req_ready | output | 1 | Adapter idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (R10) |
| req_addr | input | ADDR_W | Byte offset; low 10 bits decoded |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Read data, right-aligned; 0 for writes |
| be_valid | output | 1 | Back-end request valid |
| be_write | output | 1 | Back-end direction |
| be_size | output | 2 | Back-end native size code |
| be_addr | output | 9 | Back-end byte offset |
| be_wdata | output | 32 | Back-end write data, right-aligned |
| be_ack | input | 1 | Back-end completion for the held request |
| be_rdata | input | 32 | Back-end read data, valid with be_ack |

## Verification
On every cycle the assertions check the handshake rules: the back-end request stays stable until acknowledged, ready is low while the back end is busy, and the response is a single pulse. They also check that each back-end cycle is naturally aligned and matches the width table, and that reset leaves the adapter idle. The data-path behaviour can only be shown by the bench scenarios, which run each access against a byte-level reference of the register contents. These are the big-endian splitting order, lane extraction, read-merge-write preserving neighbouring bytes, offset masking, and the absence of any cycle for invalid or unimplemented locations.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_RESP} seq_state_t;

  // Width code per 4-byte group: 0 none, 1 byte, 2 halfword, 3 word.
  // Regions of 16 groups (64 bytes) share one width.
  function automatic logic [1:0] region_wcode(input int unsigned grp);
    case (grp >> 4)
      0:       return 2'd1;
      1:       return 2'd2;
      2:       return 2'd3;
      3:       return 2'd0;
      4:       return 2'd2;
      5:       return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  // Right-aligned mask covering (1 << lg) bytes.
  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] lg);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i < (8 << lg)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/regwin_width_rom.sv
module regwin_width_rom
  import regwin_pkg::*;
#(
  parameter int GRP_W = 7
) (
  input  logic [GRP_W-1:0] grp,
  output logic [1:0]       wcode
);
  localparam int GROUPS = 1 << GRP_W;

  logic [1:0] tbl [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_ent
    assign tbl[g] = region_wcode(g);
  end

  assign wcode = tbl[grp];
endmodule

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int OFS_W  = 10,
  parameter int WIN_AW = 9
) (
  input  logic [1:0]        size,
  input  logic              write,
  input  logic [OFS_W-1:0]  ofs,
  output logic [1:0]        s_log,
  output logic [1:0]        w_log,
  output logic [WIN_AW-1:0] base,
  output logic              bypass,
  output logic              narrow,
  output logic [2:0]        nops
);
  localparam int GRP_W = WIN_AW - 2;

  logic              out_of_win;
  logic [1:0]        wcode;
  logic [WIN_AW-1:0] amask;

  assign out_of_win = |ofs[OFS_W-1:WIN_AW];
  assign s_log      = (size == 2'd3) ? 2'd2 : size;
  assign amask      = (WIN_AW'(1) << s_log) - WIN_AW'(1);
  assign base       = ofs[WIN_AW-1:0] & ~amask;

  regwin_width_rom #(.GRP_W(GRP_W)) u_rom (
    .grp   (base[WIN_AW-1:2]),
    .wcode (wcode)
  );

  assign bypass = out_of_win || (wcode == 2'd0);
  assign w_log  = (wcode == 2'd0) ? 2'd0 : wcode - 2'd1;
  assign narrow = s_log < w_log;

  always_comb begin
    if (narrow) nops = write ? 3'd2 : 3'd1;
    else        nops = 3'd1 << (s_log - w_log);
  end
endmodule

// File: rtl/regwin_lane.sv
module regwin_lane
  import regwin_pkg::*;
(
  input  logic [1:0]        s_log,
  input  logic [1:0]        w_log,
  input  logic [1:0]        off,
  input  logic [DATA_W-1:0] narrow_in,
  input  logic [DATA_W-1:0] reg_in,
  output logic [DATA_W-1:0] extract,
  output logic [DATA_W-1:0] merged
);
  logic [2:0]        w_bytes, s_bytes, sh_bytes;
  logic [5:0]        shamt;
  logic [DATA_W-1:0] smask;

  always_comb begin
    w_bytes  = 3'd1 << w_log;
    s_bytes  = 3'd1 << s_log;
    sh_bytes = (s_log < w_log) ? (w_bytes - s_bytes - {1'b0, off}) : 3'd0;
    shamt    = {sh_bytes, 3'b000};
    smask    = lane_mask(s_log);
    extract  = (reg_in >> shamt) & smask;
    merged   = (reg_in & ~(smask << shamt)) | ((narrow_in & smask) << shamt);
  end
endmodule

// File: rtl/regwin_adapter.sv
module regwin_adapter
  import regwin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 10,
  parameter int WIN_AW = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              be_valid,
  output logic              be_write,
  output logic [1:0]        be_size,
  output logic [WIN_AW-1:0] be_addr,
  output logic [DATA_W-1:0] be_wdata,
  input  logic              be_ack,
  input  logic [DATA_W-1:0] be_rdata
);
  localparam int GRP_W = WIN_AW - 2;

  logic addr_unused;
  assign addr_unused = ^req_addr[ADDR_W-1:OFS_W];

  // Request decode
  logic [1:0]        d_s, d_w;
  logic [WIN_AW-1:0] d_base;
  logic              d_bypass, d_narrow;
  logic [2:0]        d_nops;

  regwin_decode #(.OFS_W(OFS_W), .WIN_AW(WIN_AW)) u_dec (
    .size   (req_size),
    .write  (req_write),
    .ofs    (req_addr[OFS_W-1:0]),
    .s_log  (d_s),
    .w_log  (d_w),
    .base   (d_base),
    .bypass (d_bypass),
    .narrow (d_narrow),
    .nops   (d_nops)
  );

  // Transaction state
  seq_state_t        state;
  logic [1:0]        t_s, t_w;
  logic [WIN_AW-1:0] t_base;
  logic              t_write, t_narrow;
  logic [DATA_W-1:0] t_wdata, t_acc;
  logic [2:0]        t_nops, t_idx;

  // Lane datapath
  logic [1:0]        ln_off;
  logic [DATA_W-1:0] ln_extract, ln_merged;

  assign ln_off = t_base[1:0] & ((2'd1 << t_w) - 2'd1);

  regwin_lane u_lane (
    .s_log     (t_s),
    .w_log     (t_w),
    .off       (ln_off),
    .narrow_in (t_wdata),
    .reg_in    (be_rdata),
    .extract   (ln_extract),
    .merged    (ln_merged)
  );

  // Next back-end operation
  logic [1:0]        cw;
  logic [WIN_AW-1:0] cbase, wmask_a;
  logic              cwrite, cnarrow;
  logic [DATA_W-1:0] cwd, piece;
  logic [2:0]        cnops, cidx;
  logic [4:0]        pb;
  logic [WIN_AW-1:0] nx_addr;
  logic              nx_write;
  logic [1:0]        nx_size;
  logic [DATA_W-1:0] nx_wdata;

  always_comb begin
    if (state == ST_IDLE) begin
      cw = d_w; cbase = d_base; cwrite = req_write; cnarrow = d_narrow;
      cwd = req_wdata; cnops = d_nops; cidx = 3'd0;
    end else begin
      cw = t_w; cbase = t_base; cwrite = t_write; cnarrow = t_narrow;
      cwd = t_wdata; cnops = t_nops; cidx = t_idx + 3'd1;
    end
    wmask_a = (WIN_AW'(1) << cw) - WIN_AW'(1);
    pb      = 5'(cnops - 3'd1 - cidx) << cw;
    piece   = (cwd >> {pb, 3'b000}) & lane_mask(cw);
    if (cnarrow) begin
      nx_addr  = cbase & ~wmask_a;
      nx_write = cwrite && (cidx == 3'd1);
      nx_wdata = ln_merged;
    end else begin
      nx_addr  = cbase + (WIN_AW'(cidx) << cw);
      nx_write = cwrite;
      nx_wdata = piece;
    end
    nx_size = cw;
  end

  // Completion bookkeeping for the current back-end cycle
  logic              last_op;
  logic [DATA_W-1:0] acc_n;

  assign last_op = (t_idx + 3'd1) == t_nops;
  assign acc_n   = (t_acc << (6'd8 << t_w)) | (be_rdata & lane_mask(t_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      be_valid  <= 1'b0;
      be_write  <= 1'b0;
      be_size   <= 2'd0;
      be_addr   <= '0;
      be_wdata  <= '0;
      t_s       <= 2'd0;
      t_w       <= 2'd0;
      t_base    <= '0;
      t_write   <= 1'b0;
      t_narrow  <= 1'b0;
      t_wdata   <= '0;
      t_acc     <= '0;
      t_nops    <= 3'd0;
      t_idx     <= 3'd0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            req_ready <= 1'b0;
            t_s       <= d_s;
            t_w       <= d_w;
            t_base    <= d_base;
            t_write   <= req_write;
            t_narrow  <= d_narrow;
            t_wdata   <= req_wdata;
            t_nops    <= d_nops;
            t_idx     <= 3'd0;
            t_acc     <= '0;
            if (d_bypass) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= '0;
              state     <= ST_RESP;
            end else begin
              be_valid <= 1'b1;
              be_write <= nx_write;
              be_size  <= nx_size;
              be_addr  <= nx_addr;
              be_wdata <= nx_wdata;
              state    <= ST_BUSY;
            end
          end
        end
        ST_BUSY: begin
          if (be_ack) begin
            if (last_op) begin
              be_valid  <= 1'b0;
              rsp_valid <= 1'b1;
              rsp_rdata <= t_write ? '0 : (t_narrow ? ln_extract : acc_n);
              state     <= ST_RESP;
            end else begin
              be_write <= nx_write;
              be_size  <= nx_size;
              be_addr  <= nx_addr;
              be_wdata <= nx_wdata;
              t_idx    <= t_idx + 3'd1;
              t_acc    <= acc_n;
            end
          end
        end
        default: begin
          rsp_valid <= 1'b0;
          req_ready <= 1'b1;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  // Independent width lookup on the issued address for checking
  logic [1:0] chk_wcode;

  regwin_width_rom #(.GRP_W(GRP_W)) u_chk_rom (
    .grp   (be_addr[WIN_AW-1:2]),
    .wcode (chk_wcode)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (req_ready && !rsp_valid && !be_valid));

  // R3
  width_match_chk: assert property (@(posedge clk) disable iff (rst)
    be_valid |-> (chk_wcode != 2'd0) && (be_size == chk_wcode - 2'd1));

  // R10
  be_align_chk: assert property (@(posedge clk) disable iff (rst)
    be_valid |-> ((be_addr & ((WIN_AW'(1) << be_size) - WIN_AW'(1))) == '0));

  // R9
  be_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (be_valid && !be_ack) |=> (be_valid && $stable(be_addr) && $stable(be_size)
                               && $stable(be_write) && $stable(be_wdata)));

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    be_valid |-> !req_ready);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/sim_regwin_adapter.sv
`timescale 1ns/100ps
module sim_regwin_adapter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        be_valid, be_write;
  logic [1:0]  be_size;
  logic [8:0]  be_addr;
  logic [31:0] be_wdata;
  logic        be_ack = 1'b0;
  logic [31:0] be_rdata = '0;

  always #2.5 clk = ~clk;

  regwin_adapter u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .be_valid(be_valid), .be_write(be_write), .be_size(be_size),
    .be_addr(be_addr), .be_wdata(be_wdata), .be_ack(be_ack), .be_rdata(be_rdata)
  );

  int checks = 0;
  int failures = 0;
  int lat = 0;
  int wait_cnt = 0;
  int op_total = 0;
  int cycles = 0;
  logic [8:0] log_addr [64];
  logic [1:0] log_size [64];
  logic       log_wr   [64];
  logic [7:0] mem  [512];
  logic [7:0] refm [512];

  function automatic logic [7:0] init_byte(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // Back-end register model
  always @(posedge clk) begin
    if (rst) begin
      be_ack   <= 1'b0;
      wait_cnt <= 0;
      for (int i = 0; i < 512; i++) mem[i] = init_byte(i);
    end else if (be_ack) begin
      be_ack <= 1'b0;
      wait_cnt <= 0;
      log_addr[op_total & 63] <= be_addr;
      log_size[op_total & 63] <= be_size;
      log_wr[op_total & 63]   <= be_write;
      op_total <= op_total + 1;
      if (be_write)
        for (int i = 0; i < (1 << be_size); i++)
          mem[be_addr + i] = 8'(be_wdata >> (((1 << be_size) - 1 - i) * 8));
    end else if (be_valid) begin
      if (wait_cnt >= lat) begin
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < (1 << be_size); i++) r = (r << 8) | 32'(mem[be_addr + i]);
        be_rdata <= r;
        be_ack   <= 1'b1;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
    end
  end

  // Width map from R3: -1 unimplemented, else log2 bytes
  function automatic int map_log(input int ofs);
    case ((ofs >> 6) & 7)
      0, 6, 7: return 0;
      1, 4:    return 1;
      2, 5:    return 2;
      default: return -1;
    endcase
  endfunction

  function automatic int size_log(input logic [1:0] sz);
    return (sz == 2'd3) ? 2 : int'(sz);
  endfunction

  function automatic logic [31:0] ref_read(input int a, input int sl);
    logic [31:0] r;
    int al;
    al = a & ~((1 << sl) - 1);
    r = '0;
    for (int i = 0; i < (1 << sl); i++) r = (r << 8) | 32'(refm[al + i]);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // One front-end transaction; updates the reference on valid writes.
  task automatic access(input bit wr, input logic [1:0] sz, input logic [15:0] addr,
                        input logic [31:0] wd, output logic [31:0] rd, output int nops);
    int n0, cnt, ofs, sl;
    n0 = op_total;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0;
    while (!rsp_valid && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    rd = rsp_rdata;
    nops = op_total - n0;
    ofs = int'(addr) & 1023;
    sl  = size_log(sz);
    if (wr && ofs < 512 && map_log(ofs) >= 0) begin
      int al;
      al = ofs & ~((1 << sl) - 1);
      for (int i = 0; i < (1 << sl); i++)
        refm[al + i] = 8'(wd >> (((1 << sl) - 1 - i) * 8));
    end
  endtask

  task automatic t_reset;
    chk(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
    chk(be_valid === 1'b0, "R1 be_valid after reset", 32'(be_valid), 0);
  endtask

  task automatic t_matched;
    logic [31:0] rd; int n;
    access(1, 2'd0, 16'h0005, 32'h0000_005A, rd, n);
    chk(n == 1, "R4 byte write op count", n, 1);
    access(0, 2'd0, 16'h0005, 0, rd, n);
    chk(rd == 32'h5A, "R4 byte readback", rd, 32'h5A);
    access(1, 2'd1, 16'h0044, 32'h0000_A1B2, rd, n);
    chk(n == 1 && log_size[(op_total - 1) & 63] == 2'd1, "R4 half write single op", n, 1);
    access(0, 2'd1, 16'h0044, 0, rd, n);
    chk(rd == 32'hA1B2, "R4 half readback", rd, 32'hA1B2);
    access(1, 2'd2, 16'h0088, 32'hCAFE_F00D, rd, n);
    access(0, 2'd2, 16'h0088, 0, rd, n);
    chk(rd == 32'hCAFE_F00D && n == 1, "R4 word readback", rd, 32'hCAFE_F00D);
  endtask

  task automatic t_word_to_half;
    logic [31:0] rd; int n, b;
    access(1, 2'd2, 16'h0048, 32'h1122_3344, rd, n);
    b = op_total - 2;
    chk(n == 2, "R5 word-to-half op count", n, 2);
    chk(log_addr[b & 63] == 9'h048 && log_addr[(b + 1) & 63] == 9'h04A,
        "R5 upper half first", 32'(log_addr[b & 63]), 32'h048);
    chk(mem[9'h048] == 8'h11 && mem[9'h04B] == 8'h44, "R5 back-end bytes", 32'(mem[9'h048]), 32'h11);
    access(0, 2'd2, 16'h0048, 0, rd, n);
    chk(rd == 32'h1122_3344, "R5 word read of halves", rd, 32'h1122_3344);
  endtask

  task automatic t_byte_region;
    logic [31:0] rd, ex; int n, b;
    access(1, 2'd1, 16'h0010, 32'h0000_BEEF, rd, n);
    b = op_total - 2;
    chk(n == 2 && log_addr[b & 63] == 9'h010 && log_addr[(b + 1) & 63] == 9'h011,
        "R6 half to bytes order", n, 2);
    chk(mem[9'h010] == 8'hBE && mem[9'h011] == 8'hEF, "R6 high byte at low address", 32'(mem[9'h010]), 32'hBE);
    ex = ref_read(9'h180, 2);
    access(0, 2'd2, 16'h0180, 0, rd, n);
    chk(n == 4, "R6 word to bytes op count", n, 4);
    chk(rd == ex, "R6 word read of bytes", rd, ex);
  endtask

  task automatic t_narrow_read;
    logic [31:0] rd, ex; int b;
    int n;
    ex = ref_read(9'h081, 0);
    access(0, 2'd0, 16'h0081, 0, rd, n);
    b = op_total - 1;
    chk(n == 1 && log_addr[b & 63] == 9'h080 && log_size[b & 63] == 2'd2,
        "R7 aligned word read", 32'(log_addr[b & 63]), 32'h080);
    chk(rd == ex, "R7 byte lane of word", rd, ex);
    ex = ref_read(9'h047, 0);
    access(0, 2'd0, 16'h0047, 0, rd, n);
    chk(rd == ex, "R7 low byte of halfword", rd, ex);
  endtask

  task automatic t_rmw;
    logic [31:0] rd, ex; int n, b;
    access(1, 2'd0, 16'h0082, 32'h0000_00C3, rd, n);
    b = op_total - 2;
    chk(n == 2 && log_wr[b & 63] == 1'b0 && log_wr[(b + 1) & 63] == 1'b1,
        "R8 read then write", n, 2);
    ex = ref_read(9'h080, 2);
    access(0, 2'd2, 16'h0080, 0, rd, n);
    chk(rd == ex, "R8 byte merge into word", rd, ex);
    access(1, 2'd1, 16'h00A2, 32'h0000_7E57, rd, n);
    ex = ref_read(9'h0A0, 2);
    access(0, 2'd2, 16'h00A0, 0, rd, n);
    chk(rd == ex, "R8 half merge into word", rd, ex);
    access(1, 2'd0, 16'h0141, 32'h0000_0099, rd, n);
    ex = ref_read(9'h140, 2);
    access(0, 2'd2, 16'h0140, 0, rd, n);
    chk(rd == ex, "R8 byte merge upper word region", rd, ex);
  endtask

  task automatic t_invalid;
    logic [31:0] rd, ex; int n;
    access(0, 2'd2, 16'h0200, 0, rd, n);
    chk(rd == 0 && n == 0, "R2 read beyond window", rd, 0);
    access(1, 2'd2, 16'h02F0, 32'hFFFF_FFFF, rd, n);
    chk(n == 0, "R2 write beyond window dropped", n, 0);
    access(1, 2'd0, 16'h0430, 32'h0000_0077, rd, n);
    chk(n == 1 && log_addr[(op_total - 1) & 63] == 9'h030, "R2 offset masked to 10 bits",
        32'(log_addr[(op_total - 1) & 63]), 32'h030);
    ex = ref_read(9'h030, 0);
    access(0, 2'd0, 16'h0030, 0, rd, n);
    chk(rd == ex && rd == 32'h77, "R2 masked write landed", rd, 32'h77);
  endtask

  task automatic t_unimpl;
    logic [31:0] rd; int n;
    access(0, 2'd2, 16'h00C4, 0, rd, n);
    chk(rd == 0 && n == 0, "R3 unimplemented read", rd, 0);
    access(1, 2'd1, 16'h00F0, 32'h0000_1234, rd, n);
    chk(n == 0, "R3 unimplemented write no cycle", n, 0);
  endtask

  task automatic t_align;
    logic [31:0] rd, ex; int n;
    ex = ref_read(9'h044, 1);
    access(0, 2'd1, 16'h0045, 0, rd, n);
    chk(rd == ex && log_addr[(op_total - 1) & 63] == 9'h044, "R10 half low bit ignored", rd, ex);
    ex = ref_read(9'h088, 2);
    access(0, 2'd3, 16'h008B, 0, rd, n);
    chk(rd == ex && n == 1, "R10 size code 3 as word", rd, ex);
  endtask

  task automatic t_handshake;
    int cnt;
    lat = 3;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2; req_addr = 16'h008C; req_wdata = 32'h0BAD_CAFE;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0 && be_valid == 1'b1, "R9 ready low while busy", 32'(req_ready), 0);
    @(negedge clk);
    chk(be_valid == 1'b1 && be_addr == 9'h08C, "R9 request held until ack", 32'(be_addr), 32'h08C);
    cnt = 0;
    while (!rsp_valid && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    chk(rsp_valid == 1'b1, "R9 response seen", 32'(rsp_valid), 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 response is one cycle", 32'(rsp_valid), 0);
    for (int i = 0; i < 4; i++) refm[9'h08C + i] = 8'(32'h0BAD_CAFE >> ((3 - i) * 8));
    lat = 0;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) refm[i] = init_byte(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_matched();
    t_word_to_half();
    t_byte_region();
    t_narrow_read();
    t_rmw();
    t_invalid();
    t_unimpl();
    t_align();
    t_handshake();
    lat = 2;
    t_rmw();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule